// File: doc/BRIEF.md
# Serial Transmit Channel with Buffer Status

This block is the sending half of a register-mapped asynchronous serial port. Software writes characters into a two-entry holding buffer through a small register port. The block then sends each one on a single output line as a start bit, a configurable number of data bits (least significant first), an optional parity bit and a configurable stop period. Bit timing comes from an external tick that pulses sixteen times per bit period. The tick generator and the receive side live elsewhere.

The transmitter is switched on and off by one-shot command writes. Software learns when it may write more data from a buffer-level flag with a selectable threshold. A separate completion flag shows that the line has gone quiet. Two interrupt flags, with set, clear and enable registers, combine into one interrupt output.

Register map (4-bit word address): 0 control (bit 12 level threshold), 1 frame format, 2 command (write only), 3 status (read only), 4 transmit data (write only), 5 interrupt flags (read), 6 flag set (write), 7 flag clear (write), 8 interrupt enable (bits 1:0). Unlisted addresses read as zero.

Top module: `sio_tx_port`

## Requirements
- R1: After reset the line is high, status reads 0x0040 (buffer empty, transmitter off, no completion), the flag register reads 0x0002, the frame register reads 0x1005 and the interrupt output is low.
- R2: A command write with bit 2 set turns the transmitter on and one with bit 3 set turns it off; when both are set, off wins. Status bit 1 shows the current on/off state.
- R3: The buffer holds two characters. A transmit-data write while it holds two is dropped and never sent.
- R4: Status bit 6 (buffer level) is 1 when the buffer is empty if control bit 12 is 0, and when it holds at most one character if control bit 12 is 1.
- R5: A frame is a low start bit, then N data bits LSB first, where frame bits 3:0 hold N-3 for N in 5..8 (other codes give 8 bits). The frame format is taken when a character is loaded for sending.
- R6: Frame bits 9:8 select parity: 2 even, 3 odd, 0 or 1 none. The parity bit covers exactly the N data bits and follows the last data bit.
- R7: Every start, data and parity bit lasts 16 tick pulses. Frame bits 13:12 set the stop period: 0 gives 8 ticks, 1 gives 16, 2 gives 24, 3 gives 32. The line is high during the stop period.
- R8: Status bit 5 (complete) is set when a stop period ends with the buffer empty, and is cleared by any transmit-data write. It does not set at the end of a frame while more data is waiting.
- R9: Flag bit 0 is set by the completion event or by writing 1 to bit 0 of the set register. It stays set until bit 0 of the clear register is written. Flag bit 1 always equals status bit 6 and ignores set and clear writes.
- R10: The interrupt output is high exactly when some flag bit and its enable bit (enable register bits 1:0) are both 1.
- R11: While off, the line stays high and no frame starts. A turn-off during a frame lets that frame finish; characters still in the buffer stay there until the transmitter is turned on again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16_i | input | 1 | Oversampling tick, 16 pulses per bit |
| addr_i | input | 4 | Register word address |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Register read data for addr_i (combinational) |
| tx_o | output | 1 | Serial output line, idle high |
| irq_o | output | 1 | Interrupt request |

## Verification
A line monitor decodes every frame and compares it with a queue of expected characters and parity bits. It is fed with 8-bit no-parity, 5-bit even, 8-bit odd and 7-bit no-parity formats, so a wrong bit order, bit count or parity sense shows up as a data or parity mismatch. The cycle count from start edge to completion interrupt is checked for each of the four stop settings and for a tick at half rate. That separates stop-length decoding and tick gating from the data path. Writes made while the transmitter is off, writes made while the buffer is full, back-to-back writes and a turn-off in mid-frame show whether a character is dropped, sent or held, and whether completion waits for an empty buffer.

// File: rtl/sio_tx_pkg.sv
`timescale 1ns/1ps
package sio_tx_pkg;
  localparam int CHAR_W = 8;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_FRAME  = 4'd1;
  localparam logic [ADDR_W-1:0] A_CMD    = 4'd2;
  localparam logic [ADDR_W-1:0] A_STATUS = 4'd3;
  localparam logic [ADDR_W-1:0] A_TXDATA = 4'd4;
  localparam logic [ADDR_W-1:0] A_IF     = 4'd5;
  localparam logic [ADDR_W-1:0] A_IFS    = 4'd6;
  localparam logic [ADDR_W-1:0] A_IFC    = 4'd7;
  localparam logic [ADDR_W-1:0] A_IEN    = 4'd8;

  localparam int B_CMD_ON   = 2;
  localparam int B_CMD_OFF  = 3;
  localparam int B_ST_ON    = 1;
  localparam int B_ST_DONE  = 5;
  localparam int B_ST_LVL   = 6;
  localparam int B_CTRL_THR = 12;
  localparam int B_F_DONE   = 0;
  localparam int B_F_LVL    = 1;

  localparam logic [REG_W-1:0] FRAME_RST  = 16'h1005;
  localparam logic [REG_W-1:0] FRAME_MASK = 16'h330F;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } ser_state_e;

  typedef struct packed {
    logic [3:0] nbits;
    logic       par_en;
    logic       par_odd;
    logic [7:0] stop_ticks;
  } frame_cfg_t;

  // Length code to data-bit count; codes outside 2..5 mean eight bits.
  function automatic logic [3:0] bits_of_code(input logic [3:0] code);
    if (code >= 4'd2 && code <= 4'd5) return code + 4'd3;
    return 4'd8;
  endfunction

  // Stop period in ticks: half a bit per code step, plus half a bit.
  function automatic logic [7:0] stop_ticks_of(input logic [1:0] code, input int ovs);
    logic [7:0] half;
    half = 8'(ovs / 2);
    return half * ({6'd0, code} + 8'd1);
  endfunction

  function automatic frame_cfg_t decode_frame(input logic [REG_W-1:0] f, input int ovs);
    frame_cfg_t c;
    c.nbits      = bits_of_code(f[3:0]);
    c.par_en     = f[9];
    c.par_odd    = f[8];
    c.stop_ticks = stop_ticks_of(f[13:12], ovs);
    return c;
  endfunction

  function automatic logic parity_of(input logic [CHAR_W-1:0] d, input logic [3:0] n,
                                     input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < CHAR_W; i++) begin
      if (i < int'(n)) p = p ^ d[i];
    end
    return p;
  endfunction
endpackage

// File: rtl/sio_tx_fifo.sv
`timescale 1ns/1ps
module sio_tx_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  a_r3_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == CNT_W'(DEPTH)));
endmodule

// File: rtl/sio_tx_ser.sv
`timescale 1ns/1ps
module sio_tx_ser
  import sio_tx_pkg::*;
#(
  parameter int OVS = 16,
  localparam int TCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              have_data,
  input  logic [CHAR_W-1:0] data,
  input  frame_cfg_t        cfg,
  output logic              load,
  output logic              busy,
  output logic              done,
  output logic              txd
);
  ser_state_e        st;
  logic [TCNT_W-1:0] tcnt;
  logic [TCNT_W-1:0] lim;
  logic [3:0]        bidx;
  logic [CHAR_W-1:0] sh;
  frame_cfg_t        cq;
  logic              pbit;
  logic              last_tick;

  assign lim       = (st == ST_STOP) ? cq.stop_ticks : TCNT_W'(OVS);
  assign last_tick = tick && (tcnt == lim - TCNT_W'(1));
  assign load      = en && have_data && (st == ST_IDLE);
  assign busy      = (st != ST_IDLE);
  assign done      = (st == ST_STOP) && last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      tcnt <= '0;
      bidx <= '0;
      sh   <= '0;
      cq   <= '0;
      pbit <= 1'b0;
    end else if (load) begin
      st   <= ST_START;
      tcnt <= '0;
      bidx <= '0;
      sh   <= data;
      cq   <= cfg;
      pbit <= parity_of(data, cfg.nbits, cfg.par_odd);
    end else if (busy && tick) begin
      if (last_tick) begin
        tcnt <= '0;
        case (st)
          ST_START: st <= ST_DATA;
          ST_DATA: begin
            sh   <= sh >> 1;
            bidx <= bidx + 4'd1;
            if (bidx == cq.nbits - 4'd1) st <= cq.par_en ? ST_PAR : ST_STOP;
          end
          ST_PAR:  st <= ST_STOP;
          default: st <= ST_IDLE;
        endcase
      end else begin
        tcnt <= tcnt + TCNT_W'(1);
      end
    end
  end

  always_comb begin
    case (st)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = sh[0];
      ST_PAR:   txd = pbit;
      default:  txd = 1'b1;
    endcase
  end

  a_r11_start_needs_on: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START && $past(st) == ST_IDLE) |-> $past(en));
  a_r7_stop_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (st == ST_IDLE));
  a_r6_parity_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PAR) |-> ($past(st) == ST_DATA || $past(st) == ST_PAR));
endmodule

// File: rtl/sio_tx_port.sv
`timescale 1ns/1ps
module sio_tx_port
  import sio_tx_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int OVS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              tx_o,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              tx_on, thr_sel, flag_done, done_st;
  logic [REG_W-1:0]  frame_q;
  logic [1:0]        ien_q;
  logic              wr_ctrl, wr_frame, wr_cmd, wr_data, wr_ifs, wr_ifc, wr_ien;
  logic [CHAR_W-1:0] fifo_dout;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              fifo_full, fifo_empty;
  logic              ser_load, ser_busy, ser_done;
  logic              level_ok, done_event;
  logic [1:0]        flags;
  frame_cfg_t        cfg;

  assign wr_ctrl  = wr_en_i && (addr_i == A_CTRL);
  assign wr_frame = wr_en_i && (addr_i == A_FRAME);
  assign wr_cmd   = wr_en_i && (addr_i == A_CMD);
  assign wr_data  = wr_en_i && (addr_i == A_TXDATA);
  assign wr_ifs   = wr_en_i && (addr_i == A_IFS);
  assign wr_ifc   = wr_en_i && (addr_i == A_IFC);
  assign wr_ien   = wr_en_i && (addr_i == A_IEN);

  assign cfg = decode_frame(frame_q, OVS);

  sio_tx_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wr_data),
    .pop   (ser_load),
    .din   (wr_data_i[CHAR_W-1:0]),
    .dout  (fifo_dout),
    .count (fifo_cnt),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  sio_tx_ser #(.OVS(OVS)) ser_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16_i),
    .en        (tx_on),
    .have_data (!fifo_empty),
    .data      (fifo_dout),
    .cfg       (cfg),
    .load      (ser_load),
    .busy      (ser_busy),
    .done      (ser_done),
    .txd       (tx_o)
  );

  assign level_ok   = thr_sel ? (fifo_cnt <= CNT_W'(DEPTH / 2)) : fifo_empty;
  assign done_event = ser_done && fifo_empty;
  assign flags      = {level_ok, flag_done};
  assign irq_o      = |(flags & ien_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_on     <= 1'b0;
      thr_sel   <= 1'b0;
      frame_q   <= FRAME_RST;
      ien_q     <= '0;
      flag_done <= 1'b0;
      done_st   <= 1'b0;
    end else begin
      if (wr_cmd) begin
        if (wr_data_i[B_CMD_OFF])     tx_on <= 1'b0;
        else if (wr_data_i[B_CMD_ON]) tx_on <= 1'b1;
      end
      if (wr_ctrl)  thr_sel <= wr_data_i[B_CTRL_THR];
      if (wr_frame) frame_q <= wr_data_i & FRAME_MASK;
      if (wr_ien)   ien_q   <= wr_data_i[1:0];
      if (wr_data)         done_st <= 1'b0;
      else if (done_event) done_st <= 1'b1;
      if (done_event || (wr_ifs && wr_data_i[B_F_DONE]))
        flag_done <= 1'b1;
      else if (wr_ifc && wr_data_i[B_F_DONE])
        flag_done <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      A_CTRL:   rd_data_o[B_CTRL_THR] = thr_sel;
      A_FRAME:  rd_data_o = frame_q;
      A_STATUS: begin
        rd_data_o[B_ST_ON]   = tx_on;
        rd_data_o[B_ST_DONE] = done_st;
        rd_data_o[B_ST_LVL]  = level_ok;
      end
      A_IF:     rd_data_o[1:0] = flags;
      A_IEN:    rd_data_o[1:0] = ien_q;
      default:  rd_data_o = '0;
    endcase
  end

  a_r2_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wr_data_i[B_CMD_OFF]) |=> !tx_on);
  a_r8_done_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_st) |-> (fifo_empty && !ser_busy));
  a_r9_done_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_done) && !($past(wr_ifc) && $past(wr_data_i[B_F_DONE]))) |-> flag_done);
  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 2'b00) |-> !irq_o);
  a_r11_off_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_on |-> !ser_load);
endmodule

// File: tb/sio_tx_port_tb.sv
`timescale 1ns/1ps
module sio_tx_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  addr;
  logic        wr_en;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        tx_o, irq_o, tick;
  int          tick_div = 1;
  logic [3:0]  tdiv_cnt = 4'd0;

  typedef struct {logic [7:0] d; logic pe; logic p;} exp_t;
  exp_t exp_q[$];

  int tests = 0, fails = 0, mon_frames = 0;
  int b_bits = 8;
  logic b_pe = 1'b0, b_odd = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) tdiv_cnt <= (int'(tdiv_cnt) >= tick_div - 1) ? 4'd0 : tdiv_cnt + 4'd1;
  assign tick = (tdiv_cnt == 4'd0);

  sio_tx_port dut_i (
    .clk(clk), .rst_n(rst_n), .tick16_i(tick), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_data_o(rdata), .tx_o(tx_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    #1 v = rdata;
  endtask

  task automatic set_frame(input logic [15:0] f);
    int code;
    wr(4'd1, f);
    code = int'(f[3:0]);
    b_bits = (code >= 2 && code <= 5) ? code + 3 : 8;
    b_pe  = f[9];
    b_odd = f[8];
  endtask

  // Driver: record the expected character, then write it.
  task automatic send(input logic [7:0] d, input bit accepted);
    exp_t e;
    logic [7:0] m;
    m = 8'((9'd1 << b_bits) - 9'd1);
    e.d = d & m;
    e.pe = b_pe;
    e.p = b_odd ^ (^(d & m));
    if (accepted) exp_q.push_back(e);
    wr(4'd4, {8'd0, d});
  endtask

  task automatic frame_len(output int c);
    while (tx_o !== 1'b0) @(negedge clk);
    c = 0;
    while (irq_o !== 1'b1 && c < 5000) begin
      @(negedge clk);
      c++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: decode each frame on the line and compare with the queue.
  logic [7:0] got;
  logic       gp;
  exp_t       ge;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && tx_o === 1'b0) begin
        got = '0; gp = 1'b0;
        repeat (8 * tick_div - 1) @(negedge clk);
        chk(tx_o === 1'b0, "R5 start bit low", tx_o, 0);
        for (int i = 0; i < b_bits; i++) begin
          repeat (16 * tick_div) @(negedge clk);
          got[i] = tx_o;
        end
        if (b_pe) begin
          repeat (16 * tick_div) @(negedge clk);
          gp = tx_o;
        end
        repeat (10 * tick_div) @(negedge clk);
        chk(tx_o === 1'b1, "R7 stop period high", tx_o, 1);
        mon_frames++;
        if (exp_q.size() == 0) chk(1'b0, "R3/R11 unexpected frame", got, 0);
        else begin
          ge = exp_q.pop_front();
          chk(got == ge.d, "R5 data bits", got, ge.d);
          if (ge.pe) chk(gp == ge.p, "R6 parity bit", gp, ge.p);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  logic [15:0] v;
  int c, f0;
  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk(tx_o === 1'b1, "R1 line idle high", tx_o, 1);
    chk(irq_o === 1'b0, "R1 irq low", irq_o, 0);
    rd(4'd3, v); chk(v == 16'h0040, "R1 status", v, 16'h0040);
    rd(4'd5, v); chk(v == 16'h0002, "R1 flags", v, 16'h0002);
    rd(4'd1, v); chk(v == 16'h1005, "R1 frame reset", v, 16'h1005);

    // R11/R3/R4: transmitter off, fill buffer
    send(8'hA5, 1);
    idle(200);
    chk(exp_q.size() == 1 && tx_o === 1'b1, "R11 no frame while off", exp_q.size(), 1);
    rd(4'd3, v); chk(v[6] == 1'b0, "R4 level one entry thr0", v[6], 0);
    wr(4'd0, 16'h1000);
    rd(4'd3, v); chk(v[6] == 1'b1, "R4 level one entry thr1", v[6], 1);
    send(8'h3C, 1);
    rd(4'd3, v); chk(v[6] == 1'b0, "R4 level two entries thr1", v[6], 0);
    rd(4'd5, v); chk(v[1] == 1'b0, "R9 level flag tracks status", v[1], 0);
    send(8'hFF, 0);  // dropped: buffer full
    f0 = mon_frames;
    wr(4'd2, 16'h0004);
    rd(4'd3, v); chk(v[1] == 1'b1, "R2 on status", v[1], 1);
    idle(450);
    chk(mon_frames - f0 == 2, "R3 only two frames sent", mon_frames - f0, 2);
    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    rd(4'd3, v); chk(v[5] == 1'b1, "R8 complete status", v[5], 1);
    rd(4'd5, v); chk(v == 16'h0003, "R9 complete flag set", v, 3);

    // R9 set/clear
    wr(4'd7, 16'h0003);
    rd(4'd5, v); chk(v == 16'h0002, "R9 clear ignores level bit", v, 2);
    wr(4'd6, 16'h0001);
    rd(4'd5, v); chk(v == 16'h0003, "R9 set register", v, 3);
    wr(4'd7, 16'h0001);
    // R10 masking
    chk(irq_o === 1'b0, "R10 irq masked", irq_o, 0);
    wr(4'd8, 16'h0002);
    idle(1); chk(irq_o === 1'b1, "R10 level enable", irq_o, 1);
    wr(4'd8, 16'h0001);
    idle(1); chk(irq_o === 1'b0, "R10 done flag clear", irq_o, 0);
    wr(4'd6, 16'h0001);
    idle(1); chk(irq_o === 1'b1, "R10 done flag enabled", irq_o, 1);
    wr(4'd7, 16'h0001);

    // R7/R5/R6 frame lengths for four formats
    set_frame(16'h1005);
    send(8'hA5, 1);
    rd(4'd3, v); chk(v[5] == 1'b0, "R8 write clears complete", v[5], 0);
    frame_len(c); chk(c == 160, "R7 8N1 length", c, 160);
    wr(4'd7, 16'h0001);
    set_frame(16'h3202);
    send(8'h13, 1);
    frame_len(c); chk(c == 144, "R7 5E2 length", c, 144);
    wr(4'd7, 16'h0001);
    set_frame(16'h0305);
    send(8'hC1, 1);
    frame_len(c); chk(c == 168, "R7 8O half stop length", c, 168);
    wr(4'd7, 16'h0001);
    set_frame(16'h2004);
    send(8'h5A, 1);
    frame_len(c); chk(c == 152, "R7 7N 1.5 stop length", c, 152);
    wr(4'd7, 16'h0001);
    idle(20);
    chk(exp_q.size() == 0, "R5 all formats received", exp_q.size(), 0);

    // R8 back-to-back: no completion between frames
    set_frame(16'h1005);
    wr(4'd8, 16'h0000);
    send(8'h01, 1); send(8'h80, 1); send(8'h7E, 1);
    idle(200);
    rd(4'd5, v); chk(v[0] == 1'b0, "R8 no complete while data waits", v[0], 0);
    idle(400);
    rd(4'd5, v); chk(v[0] == 1'b1, "R8 complete after last frame", v[0], 1);
    chk(exp_q.size() == 0, "R8 three frames received", exp_q.size(), 0);

    // R11 off mid-frame
    send(8'h96, 1); send(8'h69, 1);
    idle(40);
    wr(4'd2, 16'h0008);
    rd(4'd3, v); chk(v[1] == 1'b0, "R2 off status", v[1], 0);
    idle(400);
    chk(exp_q.size() == 1 && tx_o === 1'b1, "R11 current frame finished, next held", exp_q.size(), 1);
    rd(4'd3, v); chk(v[6] == 1'b1, "R4 one held entry thr1", v[6], 1);
    wr(4'd2, 16'h000C);
    rd(4'd3, v); chk(v[1] == 1'b0, "R2 off wins over on", v[1], 0);
    wr(4'd2, 16'h0004);
    idle(250);
    chk(exp_q.size() == 0, "R11 held frame sent after on", exp_q.size(), 0);

    // R7 half-rate tick
    tick_div = 2;
    idle(4);
    wr(4'd7, 16'h0001);
    wr(4'd8, 16'h0001);
    send(8'h4B, 1);
    frame_len(c); chk(c >= 319 && c <= 321, "R7 half-rate tick length", c, 320);
    idle(20);
    chk(exp_q.size() == 0, "R7 half-rate frame received", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule